// File: doc/BRIEF.md
# Row/Column Static RAM Model

This block models a small byte-wide static RAM with a shared bidirectional data bus and three active-low controls: chip select, output enable and write enable. There are 256 bytes, reached through an 8-bit address. Inside, the storage is split into eight one-bit planes, one for each data bit. Each plane is a 16x16 matrix of cells, and all eight planes are addressed together to form a byte. The high address nibble picks the matrix row and the low nibble picks the column. Cells hold their value for as long as the model exists. They need no refresh, and a controller reset does not clear them.

Reads are combinational. When the chip is selected, output enable is low and write enable is high, the byte at the current address appears on the bus without waiting for a clock edge. The latency is the same for every address. Write enable overrides output enable. While both chip select and write enable are low, the block does not drive the bus and reads the byte on it instead. The write is latched when the access ends, which happens when write enable or chip select rises. The value stored is the bus value seen at the last clock edge of the access.

A small controller, clocked by `clk`, tracks the bus cycle. It has three states:
- `ST_IDLE`: no access.
- `ST_READ`: a read is in progress.
- `ST_WRITE`: a write is in progress.

Its transitions are:
- Any state goes to `ST_WRITE` while a write is active.
- Otherwise it goes to `ST_READ` while a read is active.
- Otherwise it goes to `ST_IDLE`.
- Leaving `ST_WRITE` (to `ST_READ` or `ST_IDLE`) is the commit transition that stores the held byte.
- Reset forces `ST_IDLE`.

Top module: `sram_rc`

## Requirements
- R1: Address bits [7:4] select the row and bits [3:0] select the column. All 256 addresses hold independent bytes.
- R2: Each of the eight data bits is stored in its own plane. Any bit pattern, including walking ones and walking zeros, is stored and returned exactly.
- R3: A write happens while `cs_n`=0 and `we_n`=0, whatever the level of `oe_n`. The byte is stored when `we_n` or `cs_n` rises. The value stored is the bus value at the last rising clock edge while both were low.
- R4: While a write is active, the block does not drive `dq`, even with `oe_n`=0. The bus carries the external driver's value.
- R5: With `cs_n`=0, `oe_n`=0 and `we_n`=1, `dq` shows the byte at `addr` combinationally, with no clock edge, for every address.
- R6: With `cs_n`=1, `dq` is high-impedance, and a low `we_n` leaves every cell unchanged.
- R7: With `cs_n`=0, `oe_n`=1 and `we_n`=1, `dq` is high-impedance.
- R8: Stored bytes persist across long idle periods and across controller reset, with no refresh.
- R9: Reset returns the controller to `ST_IDLE`. A write whose enable is withdrawn while reset is held stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high controller reset (cells are not cleared) |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low, overrides `oe_n` |
| addr | input | 8 | Byte address: row in [7:4], column in [3:0] |
| dq | inout | 8 | Shared data bus: driven on reads, sampled on writes |

## Verification
The assertions check several properties on every cycle:
- A committed bit lands in the addressed cell of its plane.
- Cells stay unchanged on every cycle without a commit.
- The controller enters `ST_WRITE` only after selected write pins.
- A deselected chip never commits.
- Reset leaves the controller in `ST_IDLE`.

Some behaviour is only visible from the bench scenarios:
- Correct row/column decoding over all 256 addresses.
- The combinational read path.
- The high-impedance bus, made visible by a pull-up over a stored zero byte.
- The rule that the last sampled byte before the enable rises is the one kept.
- Retention across a reset.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;
    localparam int ROW_BITS  = 4;
    localparam int COL_BITS  = 4;
    localparam int WORD_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;
endpackage

// File: rtl/sram_rc_plane.sv
module sram_rc_plane #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_bit,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic             rd_bit
);
    localparam int NROWS = 1 << ROW_W;
    localparam int NCOLS = 1 << COL_W;

    // one bit per cell; no reset so contents survive controller reset
    logic [NROWS-1:0][NCOLS-1:0] cells;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row][wr_col] <= wr_bit;
        end
    end

    assign rd_bit = cells[rd_row][rd_col];

    // R3: a commit places the bit in the addressed cell
    a_r3_cell_takes_bit: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cells[$past(wr_row)][$past(wr_col)] == $past(wr_bit));

    // R8: without a commit the whole matrix holds
    a_r8_cells_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cells));
endmodule

// File: rtl/sram_rc_ctrl.sv
module sram_rc_ctrl
    import sram_rc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic              commit,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data
);
    bus_state_e state, state_nx;
    logic wr_act, rd_act;

    assign wr_act = !cs_n && !we_n;
    assign rd_act = !cs_n && !oe_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (wr_act)      state_nx = ST_WRITE;
                else if (rd_act) state_nx = ST_READ;
                else             state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs: commit on the edge that leaves ST_WRITE
    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_WRITE: commit = !wr_act;
            default:  commit = 1'b0;
        endcase
    end

    // sample address and bus on every edge of an active write
    always_ff @(posedge clk) begin
        if (wr_act) begin
            hold_addr <= addr;
            hold_data <= bus_in;
        end
    end

    // R9: reset leaves the controller idle
    a_r9_reset_to_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state == ST_IDLE);

    // R9: ST_WRITE only follows selected write pins
    a_r9_write_from_pins: assert property (@(posedge clk) disable iff (rst)
        state == ST_WRITE |-> $past(!cs_n && !we_n));

    // R6: a chip deselected for two edges never commits
    a_r6_deselect_no_commit: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !commit);
endmodule

// File: rtl/sram_rc.sv
module sram_rc
    import sram_rc_pkg::*;
#(
    parameter int ROW_W  = ROW_BITS,
    parameter int COL_W  = COL_BITS,
    parameter int DATA_W = WORD_BITS,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] dq
);
    logic              commit;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] rd_word;
    logic              drive;

    sram_rc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .bus_in    (dq),
        .commit    (commit),
        .hold_addr (hold_addr),
        .hold_data (hold_data)
    );

    // one plane per data bit, all addressed in parallel
    for (genvar b = 0; b < DATA_W; b++) begin : g_plane
        sram_rc_plane #(.ROW_W(ROW_W), .COL_W(COL_W)) u_plane (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (commit),
            .wr_row (hold_addr[ADDR_W-1 -: ROW_W]),
            .wr_col (hold_addr[COL_W-1:0]),
            .wr_bit (hold_data[b]),
            .rd_row (addr[ADDR_W-1 -: ROW_W]),
            .rd_col (addr[COL_W-1:0]),
            .rd_bit (rd_word[b])
        );
    end

    // write enable wins over output enable
    assign drive = !cs_n && !oe_n && we_n;
    assign dq    = drive ? rd_word : {DATA_W{1'bz}};
endmodule

// File: tb/sram_rc_test.sv
module sram_rc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] tb_d = 8'h00;
    logic       tb_en = 1'b0;
    wire  [7:0] dq;
    int         n_chk = 0, n_bad = 0;

    assign dq = tb_en ? tb_d : 8'hzz;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (dq[i]);
    end

    sram_rc uut (.clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n),
                 .we_n(we_n), .addr(addr), .dq(dq));

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        tb_en = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    // drive a write with d1, then d2 on the last active edge; end by we_n or cs_n
    task automatic wr(input logic [7:0] a, input logic [7:0] d1, input logic [7:0] d2,
                      input logic oe_lvl, input logic by_cs, input logic see_bus);
        @(negedge clk);
        addr = a; tb_d = d1; tb_en = 1'b1; cs_n = 1'b0; oe_n = oe_lvl; we_n = 1'b0;
        @(negedge clk);
        if (see_bus) chk("R4", dq, d1);
        tb_d = d2;
        @(negedge clk);
        if (by_cs) cs_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tb_en = 1'b0;
        #1 chk(req, dq, exp);
        idle();
    endtask

    initial begin
        #2000000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R6 reset hi-Z", dq, 8'hFF);
        rst = 1'b0;

        // R1/R3/R4: write every address, alternating oe_n during the write
        for (int a = 0; a < 256; a++)
            wr(8'(a), 8'h00, pat(8'(a)), a[0], 1'b0, (a % 32) == 0);
        // R1/R5: read every address combinationally
        for (int a = 0; a < 256; a++) rd(8'(a), pat(8'(a)), "R1/R5 sweep");

        // R1: swapped nibbles are distinct cells
        wr(8'h12, 8'hAA, 8'hAA, 1'b1, 1'b0, 1'b0);
        wr(8'h21, 8'h55, 8'h55, 1'b1, 1'b0, 1'b0);
        rd(8'h12, 8'hAA, "R1 row1col2");
        rd(8'h21, 8'h55, "R1 row2col1");

        // R2: walking ones and zeros through the planes
        for (int i = 0; i < 8; i++) begin
            wr(8'h37, 8'h00, 8'(1 << i), 1'b1, 1'b0, 1'b0);
            rd(8'h37, 8'(1 << i), "R2 walk1");
            wr(8'h37, 8'h00, ~8'(1 << i), 1'b0, 1'b0, 1'b0);
            rd(8'h37, ~8'(1 << i), "R2 walk0");
        end

        // R3: the last sampled byte is kept; ending by cs_n also commits
        wr(8'h42, 8'hC3, 8'h3C, 1'b0, 1'b0, 1'b1);
        rd(8'h42, 8'h3C, "R3 last byte");
        wr(8'h43, 8'h11, 8'h96, 1'b1, 1'b1, 1'b0);
        rd(8'h43, 8'h96, "R3 cs end");

        // R6/R7: hi-Z over a stored zero shows as pull-up FF
        wr(8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        addr = 8'h80; cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1 chk("R6 deselect hi-Z", dq, 8'hFF);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        #1 chk("R7 no enable hi-Z", dq, 8'hFF);
        idle();
        // R6: write strobe while deselected changes nothing
        @(negedge clk);
        addr = 8'h80; tb_d = 8'h5A; tb_en = 1'b1; cs_n = 1'b1; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        idle();
        rd(8'h80, 8'h00, "R6 no write deselected");

        // R9: write withdrawn under reset stores nothing
        wr(8'h90, 8'h11, 8'h11, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        addr = 8'h90; tb_d = 8'h22; tb_en = 1'b1; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        idle(); rst = 1'b0;
        #1 chk("R9 hi-Z after reset", dq, 8'hFF);
        rd(8'h90, 8'h11, "R9 aborted write");
        wr(8'h91, 8'h00, 8'h77, 1'b1, 1'b0, 1'b0);
        rd(8'h91, 8'h77, "R9 write after reset");

        // R8: retention over a long idle and a reset pulse
        repeat (2000) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 256; a += 17) rd(8'(a), pat(8'(a)), "R8 retention");
        rd(8'h42, 8'h3C, "R8 retention edit");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule